// File: doc/BRIEF.md
# GPIO Level and Blink Controller

This block controls a 32-bit bank of general-purpose pins through two registers on a simple 32-bit register bus. One register holds a level bit per pin, and the other holds a blink-enable bit per pin. A direction vector comes in from a separate direction register. For each pin that is an output, the block drives either the stored level or a shared blink phase. The phase spends half a second high and half a second low. When software reads the level register, input pins return their level after a two-flop synchroniser, and output pins return the stored level.

Each implemented bit belongs to one of two reset domains, chosen by a parameter mask. Core-domain bits return to their defaults only on the core reset. Resume-domain bits return to their defaults on the resume reset. They also return to their defaults on any bus write to a dedicated reset-control offset. Turning blink on or off never alters the stored level. Turning blink off returns the pin to its stored level.

Top module: `gpio_blink_ctrl`

## Requirements
- R1: After both resets, the level register (offset 0x0C) reads 0x1B3F0000 and the blink register (offset 0x18) reads 0x00040000. Pin 18 therefore blinks as soon as it is an output.
- R2: A pin is an output when its `pin_dir` bit is 1. An output pin with blink clear drives its stored level bit on `pin_out` (1 = high, 0 = low).
- R3: For a pin with `pin_dir` 0, the level register bit reads the `pin_in` level, delayed by a two-flop synchroniser.
- R4: An output pin with blink set drives the blink phase. The phase is high for the first HALF_CYC = CLK_HZ/2 cycles after reset release, then low for HALF_CYC cycles, and then repeats.
- R5: Blink has no effect on an input pin. `pin_out` is 0 for every pin whose `pin_dir` bit is 0.
- R6: Writing the blink register never changes the stored level. After blink is cleared, the pin drives the stored level again.
- R7: All blinking output pins toggle in the same cycle and hold the same value.
- R8: Bits outside IMPL_MASK (default 0x1F3F0000) read as 0 and ignore writes. Offsets that are not mapped read 0.
- R9: A resume reset restores only the bits in RSM_MASK (default 0x1B0C0000) to their defaults. All other bits keep their values.
- R10: Any bus write to offset 0x3C restores the RSM_MASK bits in the same way as the resume reset. Core-domain bits are left as they are.
- R11: A core reset restores only the core-domain bits (IMPL_MASK without RSM_MASK).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| core_rst_n | input | 1 | Core-domain reset, synchronous, active low |
| rsm_rst_n | input | 1 | Resume-domain reset, synchronous, active low |
| bus_wr_en | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, decoded combinationally from `bus_addr` |
| pin_dir | input | 32 | Per-pin direction, 1 = output |
| pin_in | input | 32 | Pin levels sampled from the pads |
| pin_out | output | 32 | Driven pin values |

## Verification
The bench walks a single one across all 32 level bits, with every pin set as an output. This separates implemented bits from reserved ones, and shows that each bit drives only its own pin. Mixed direction patterns, with pad values that differ from the stored levels, show whether a read returns the synchronised pad or the register. Pin 18 is timed cycle by cycle out of reset to check the blink phase length and its starting value. Each reset source is applied after the registers have been cleared to zero, so a wrong domain mask shows up as the wrong bits coming back.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int BANK_W = 32;
    localparam int ADDR_W = 8;

    typedef struct packed {
        logic [BANK_W-1:0] lvl;
        logic [BANK_W-1:0] blk;
    } gpio_regs_t;

    typedef struct packed {
        logic [BANK_W-1:0] s1;
        logic [BANK_W-1:0] s2;
    } gpio_sync_t;
endpackage

// File: rtl/gpio_blink_timebase.sv
module gpio_blink_timebase #(
    parameter int HALF_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } tb_t;

    tb_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (t_q.cnt == LAST) begin
            t_d.cnt = '0;
            t_d.ph  = ~t_q.ph;
        end else begin
            t_d.cnt = t_q.cnt + 1'b1;
        end
        if (!rst_n) begin
            t_d.cnt = '0;
            t_d.ph  = 1'b1;
        end
    end

    always_ff @(posedge clk) t_q <= t_d;

    assign phase = t_q.ph;
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] dout
);
    gpio_sync_t s_d, s_q;

    always_comb begin
        s_d.s1 = din;
        s_d.s2 = s_q.s1;
        if (!rst_n) s_d = '0;
    end

    always_ff @(posedge clk) s_q <= s_d;

    assign dout = s_q.s2;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_pkg::*;
#(
    parameter logic [BANK_W-1:0] LVL_RST   = 32'h1B3F_0000,
    parameter logic [BANK_W-1:0] BLK_RST   = 32'h0004_0000,
    parameter logic [BANK_W-1:0] IMPL_MASK = 32'h1F3F_0000,
    parameter logic [BANK_W-1:0] RSM_MASK  = 32'h1B0C_0000
) (
    input  logic              clk,
    input  logic              core_rst_n,
    input  logic              rsm_rst_n,
    input  logic              sw_rst,
    input  logic              wr_lvl,
    input  logic              wr_blk,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] lvl_q,
    output logic [BANK_W-1:0] blk_q
);
    localparam logic [BANK_W-1:0] CORE_MASK = IMPL_MASK & ~RSM_MASK;
    localparam logic [BANK_W-1:0] RSM_IMPL  = IMPL_MASK & RSM_MASK;

    gpio_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_lvl) r_d.lvl = wdata & IMPL_MASK;
        if (wr_blk) r_d.blk = wdata & IMPL_MASK;
        if (!core_rst_n) begin
            r_d.lvl = (r_d.lvl & ~CORE_MASK) | (LVL_RST & CORE_MASK);
            r_d.blk = (r_d.blk & ~CORE_MASK) | (BLK_RST & CORE_MASK);
        end
        if (!rsm_rst_n || sw_rst) begin
            r_d.lvl = (r_d.lvl & ~RSM_IMPL) | (LVL_RST & RSM_IMPL);
            r_d.blk = (r_d.blk & ~RSM_IMPL) | (BLK_RST & RSM_IMPL);
        end
    end

    always_ff @(posedge clk) r_q <= r_d;

    assign lvl_q = r_q.lvl;
    assign blk_q = r_q.blk;
endmodule

// File: rtl/gpio_blink_ctrl.sv
module gpio_blink_ctrl
    import gpio_pkg::*;
#(
    parameter int                CLK_HZ    = 50_000_000,
    parameter logic [BANK_W-1:0] LVL_RST   = 32'h1B3F_0000,
    parameter logic [BANK_W-1:0] BLK_RST   = 32'h0004_0000,
    parameter logic [BANK_W-1:0] IMPL_MASK = 32'h1F3F_0000,
    parameter logic [BANK_W-1:0] RSM_MASK  = 32'h1B0C_0000,
    parameter logic [ADDR_W-1:0] LVL_OFF   = 8'h0C,
    parameter logic [ADDR_W-1:0] BLK_OFF   = 8'h18,
    parameter logic [ADDR_W-1:0] SWRST_OFF = 8'h3C
) (
    input  logic              clk,
    input  logic              core_rst_n,
    input  logic              rsm_rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    input  logic [BANK_W-1:0] pin_dir,
    input  logic [BANK_W-1:0] pin_in,
    output logic [BANK_W-1:0] pin_out
);
    localparam int HALF_CYC = (CLK_HZ / 2 > 1) ? CLK_HZ / 2 : 2;

    logic              wr_lvl, wr_blk, sw_rst;
    logic              tb_rst_n, blink_phase;
    logic [BANK_W-1:0] lvl_q, blk_q, pin_sync;

    assign wr_lvl   = bus_wr_en && (bus_addr == LVL_OFF);
    assign wr_blk   = bus_wr_en && (bus_addr == BLK_OFF);
    assign sw_rst   = bus_wr_en && (bus_addr == SWRST_OFF);
    assign tb_rst_n = core_rst_n & rsm_rst_n;

    gpio_bank_regs #(
        .LVL_RST(LVL_RST), .BLK_RST(BLK_RST),
        .IMPL_MASK(IMPL_MASK), .RSM_MASK(RSM_MASK)
    ) u_regs (
        .clk(clk), .core_rst_n(core_rst_n), .rsm_rst_n(rsm_rst_n),
        .sw_rst(sw_rst), .wr_lvl(wr_lvl), .wr_blk(wr_blk),
        .wdata(bus_wdata), .lvl_q(lvl_q), .blk_q(blk_q)
    );

    gpio_blink_timebase #(.HALF_CYC(HALF_CYC)) u_tbase (
        .clk(clk), .rst_n(tb_rst_n), .phase(blink_phase)
    );

    gpio_in_sync u_sync (
        .clk(clk), .rst_n(core_rst_n), .din(pin_in), .dout(pin_sync)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == LVL_OFF)
            bus_rdata = ((lvl_q & pin_dir) | (pin_sync & ~pin_dir)) & IMPL_MASK;
        else if (bus_addr == BLK_OFF)
            bus_rdata = blk_q & IMPL_MASK;
    end

    for (genvar i = 0; i < BANK_W; i++) begin : g_pin
        assign pin_out[i] = IMPL_MASK[i] & pin_dir[i] &
                            (blk_q[i] ? blink_phase : lvl_q[i]);
    end
endmodule

// File: rtl/gpio_blink_ctrl_chk.sv
module gpio_blink_ctrl_chk
    import gpio_pkg::*;
#(
    parameter logic [BANK_W-1:0] LVL_RST   = 32'h1B3F_0000,
    parameter logic [BANK_W-1:0] IMPL_MASK = 32'h1F3F_0000,
    parameter logic [BANK_W-1:0] RSM_MASK  = 32'h1B0C_0000,
    parameter logic [ADDR_W-1:0] BLK_OFF   = 8'h18,
    parameter logic [ADDR_W-1:0] SWRST_OFF = 8'h3C
) (
    input logic              clk,
    input logic              core_rst_n,
    input logic              rsm_rst_n,
    input logic              bus_wr_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BANK_W-1:0] bus_rdata,
    input logic [BANK_W-1:0] pin_dir,
    input logic [BANK_W-1:0] pin_out,
    input logic [BANK_W-1:0] lvl_q,
    input logic [BANK_W-1:0] blk_q
);
    localparam logic [BANK_W-1:0] CORE_MASK = IMPL_MASK & ~RSM_MASK;

    logic [BANK_W-1:0] blinking;
    assign blinking = blk_q & pin_dir & IMPL_MASK;

    a_r5_input_quiet: assert property (@(posedge clk) disable iff (!core_rst_n || !rsm_rst_n)
        (pin_out & ~pin_dir) == '0);

    a_r6_blink_keeps_level: assert property (@(posedge clk) disable iff (!core_rst_n || !rsm_rst_n)
        (bus_wr_en && bus_addr == BLK_OFF) |=> lvl_q == $past(lvl_q));

    a_r7_in_step: assert property (@(posedge clk) disable iff (!core_rst_n || !rsm_rst_n)
        ((pin_out & blinking) == '0) || ((pin_out & blinking) == blinking));

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!core_rst_n || !rsm_rst_n)
        (bus_rdata & ~IMPL_MASK) == '0);

    a_r10_sw_reset: assert property (@(posedge clk) disable iff (!core_rst_n || !rsm_rst_n)
        (bus_wr_en && bus_addr == SWRST_OFF) |=>
            ((lvl_q & RSM_MASK & IMPL_MASK) == (LVL_RST & RSM_MASK & IMPL_MASK)));

    a_r11_core_reset: assert property (@(posedge clk) disable iff (!rsm_rst_n)
        !core_rst_n |=> ((lvl_q & CORE_MASK) == (LVL_RST & CORE_MASK)));
endmodule

bind gpio_blink_ctrl gpio_blink_ctrl_chk #(
    .LVL_RST(LVL_RST), .IMPL_MASK(IMPL_MASK), .RSM_MASK(RSM_MASK),
    .BLK_OFF(BLK_OFF), .SWRST_OFF(SWRST_OFF)
) u_chk (
    .clk(clk), .core_rst_n(core_rst_n), .rsm_rst_n(rsm_rst_n),
    .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
    .pin_dir(pin_dir), .pin_out(pin_out), .lvl_q(lvl_q), .blk_q(blk_q)
);

// File: tb/gpio_blink_ctrl_test.sv
module gpio_blink_ctrl_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          HZ   = 20;
    localparam int          HALF = HZ / 2;
    localparam logic [31:0] IMPL = 32'h1F3F_0000;
    localparam logic [31:0] RSM  = 32'h1B0C_0000;
    localparam logic [31:0] CORE = IMPL & ~RSM;
    localparam logic [31:0] LDEF = 32'h1B3F_0000;
    localparam logic [31:0] BDEF = 32'h0004_0000;

    logic        clk = 0, core_rst_n = 0, rsm_rst_n = 0, bus_wr_en = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, pin_dir = 0, pin_in = 0;
    logic [31:0] bus_rdata, pin_out;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_blink_ctrl #(.CLK_HZ(HZ)) uut (
        .clk(clk), .core_rst_n(core_rst_n), .rsm_rst_n(rsm_rst_n),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_dir(pin_dir), .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_reset(input bit core, input bit rsm);
        @(negedge clk);
        if (core) core_rst_n = 0;
        if (rsm)  rsm_rst_n = 0;
        repeat (2) @(negedge clk);
        core_rst_n = 1; rsm_rst_n = 1;
    endtask

    initial begin
        logic [31:0] rd;
        pin_dir = '1;
        repeat (3) @(negedge clk);
        core_rst_n = 1; rsm_rst_n = 1;
        // R4: phase timing on pin 18 measured from the release edge
        for (int i = 0; i < 4 * HALF; i++) begin
            #1 check("R4 pin18 blink phase", {31'b0, pin_out[18]},
                     {31'b0, ((i / HALF) % 2) == 0});
            @(negedge clk);
        end
        // R1: reset values
        bus_read(8'h0C, rd); check("R1 level reset", rd, LDEF);
        bus_read(8'h18, rd); check("R1 blink reset", rd, BDEF);
        // R2/R8: walking one across all bits, blink off
        bus_write(8'h18, 32'h0);
        for (int b = 0; b < 32; b++) begin
            bus_write(8'h0C, 32'h1 << b);
            bus_read(8'h0C, rd);
            check("R8 level readback walk", rd, (32'h1 << b) & IMPL);
            check("R2 pin drives level", pin_out, (32'h1 << b) & IMPL);
        end
        bus_write(8'h0C, 32'hFFFF_FFFF);
        bus_read(8'h0C, rd); check("R8 reserved ignore", rd, IMPL);
        bus_read(8'h04, rd); check("R8 unmapped zero", rd, 32'h0);
        // R3: mixed directions with pad values opposite to the stored levels
        bus_write(8'h0C, 32'h0F0F_0F0F);
        pin_dir = 32'h00FF_00FF; pin_in = 32'hF0F0_F0F0;
        repeat (3) @(negedge clk);
        bus_read(8'h0C, rd);
        check("R3 input readback", rd,
              ((32'h0F0F_0F0F & pin_dir) | (pin_in & ~pin_dir)) & IMPL);
        check("R5 inputs not driven", pin_out & ~pin_dir, 32'h0);
        // R5: blink on input pin 18
        pin_dir = 32'h0; pin_in = 32'h0;
        bus_write(8'h18, 32'h0004_0000);
        for (int i = 0; i < 2 * HALF + 2; i++) begin
            #1 check("R5 blink ignored on input", pin_out, 32'h0);
            @(negedge clk);
        end
        // R6: level kept across blink, restored on clear
        pin_dir = '1;
        bus_write(8'h0C, 32'h0);
        bus_write(8'h18, 32'h0104_0000);
        bus_read(8'h0C, rd); check("R6 level unchanged by blink", rd, 32'h0);
        // R7: pins 18 and 24 toggle in step; both must toggle
        begin
            int seen_hi = 0, seen_lo = 0;
            for (int i = 0; i < 2 * HALF + 2; i++) begin
                #1;
                if (pin_out[18]) seen_hi++; else seen_lo++;
                check("R7 in step", {31'b0, pin_out[24]}, {31'b0, pin_out[18]});
                @(negedge clk);
            end
            check("R4 pin toggles both ways", {31'b0, seen_hi > 0 && seen_lo > 0}, 32'h1);
        end
        bus_write(8'h0C, 32'h0004_0000);
        bus_write(8'h18, 32'h0);
        bus_read(8'h0C, rd); check("R6 level after clear", rd, 32'h0004_0000);
        check("R6 pin back to level", pin_out, 32'h0004_0000);
        // R9: resume reset only
        bus_write(8'h0C, 32'h0); bus_write(8'h18, 32'h0);
        pulse_reset(0, 1);
        bus_read(8'h0C, rd); check("R9 rsm level", rd, LDEF & RSM);
        bus_read(8'h18, rd); check("R9 rsm blink", rd, BDEF & RSM);
        // R11: core reset only
        bus_write(8'h0C, 32'h0); bus_write(8'h18, 32'h0);
        pulse_reset(1, 0);
        bus_read(8'h0C, rd); check("R11 core level", rd, LDEF & CORE);
        bus_read(8'h18, rd); check("R11 core blink", rd, BDEF & CORE);
        // R10: software reset write
        bus_write(8'h0C, 32'h0); bus_write(8'h18, 32'h0);
        bus_write(8'h3C, 32'h0);
        bus_read(8'h0C, rd); check("R10 sw level", rd, LDEF & RSM);
        bus_read(8'h18, rd); check("R10 sw blink", rd, BDEF & RSM);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule